// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the second operand of an arithmetic or load/store instruction in a small 8/16-bit processor. The decoder supplies an addressing-mode code, the argument bytes that follow the opcode, an operand-width flag, and a flag that marks a compare-and-short-jump form. The register file supplies the current DP, B and SP values. One clock later the block presents one result: either an immediate value or a 16-bit memory effective address. With it come a flag that tells the two apart, the operand width, and the total instruction length in bytes, which the fetch logic uses to advance the program counter.

Immediates come in three forms. A zero-byte form supplies an implied constant, a one-byte form carries a single byte, and a two-byte form carries a full word. Memory operands come in two forms. One is a long offset added to DP. The other is a short offset added to B or SP, which lets code reach the 256 bytes above the stack pointer as cheaply as extra registers. Multi-byte arguments arrive low byte first, in `arg_bytes[7:0]` and then `arg_bytes[15:8]`.

Top module: `opd_ea_gen`

## Requirements
- R1: While `rst` is high, after a clock edge, `out_valid`, `out_is_mem` and `out_wide` are 0, `out_value` is 0x0000 and `out_len` is 0.
- R2: A request accepted with `in_valid` high appears at the outputs after exactly one clock edge, with `out_valid` high. After an edge where `in_valid` was low, `out_valid` is 0 and `out_value`, `out_len`, `out_is_mem` and `out_wide` keep their previous values.
- R3: Mode 0 (3'b000) gives the immediate 0x0000, mode 1 (3'b001) gives the immediate 0x0001, and mode 7 (3'b111) behaves like mode 0. All three have `out_is_mem`=0 and use no argument bytes.
- R4: Mode 2 (3'b010) gives the immediate {8'h00, arg byte 0}, uses one argument byte and has `out_is_mem`=0.
- R5: Mode 3 (3'b011) uses two argument bytes and has `out_is_mem`=0. It gives {arg byte 1, arg byte 0} when `wide`=1, and {8'h00, arg byte 0} when `wide`=0.
- R6: Mode 4 (3'b100) gives the address DP + {arg byte 1, arg byte 0} modulo 65536, uses two argument bytes and has `out_is_mem`=1.
- R7: Mode 5 (3'b101) gives the address B + zero-extended arg byte 0 modulo 65536, uses one argument byte and has `out_is_mem`=1.
- R8: Mode 6 (3'b110) gives the address SP + zero-extended arg byte 0 modulo 65536, uses one argument byte and has `out_is_mem`=1.
- R9: `out_wide` equals the `wide` input of the accepted request in every mode.
- R10: `out_len` is 1 + the number of argument bytes the mode uses + 1 when `has_jump`=1 (the jump displacement byte). It is always between 1 and 4 when `out_valid` is high.
- R11: Argument bytes that the selected mode does not use, including the jump displacement byte, have no effect on `out_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing-mode code |
| wide | input | 1 | 1 selects a 16-bit operand, 0 an 8-bit operand |
| has_jump | input | 1 | Instruction carries a trailing short-jump byte |
| arg_bytes | input | 24 | Argument bytes, byte 0 in bits 7:0 |
| dp_val | input | 16 | DP register value |
| b_val | input | 16 | B register value |
| sp_val | input | 16 | SP register value |
| out_valid | output | 1 | Result valid this cycle |
| out_is_mem | output | 1 | 1 = `out_value` is an address, 0 = an immediate |
| out_wide | output | 1 | Operand width of the result |
| out_value | output | 16 | Immediate or effective address |
| out_len | output | 3 | Instruction length in bytes |

## Verification
Every mode is driven with argument bytes that differ from each other and with a nonzero byte in the unused positions. A wrong byte order, a wrong base register or a leak from an unused byte therefore shows up as a different value. The address modes are also tried with base and offset pairs that cross 0xFFFF, which separates a wrapping 16-bit sum from a carry-out or a sign-extended short offset. The long immediate is run with both widths, the jump flag is set on one- and two-byte modes to reach lengths 3 and 4, and an idle cycle after a result shows whether the outputs hold.

// File: rtl/opd_pkg.sv
package opd_pkg;

  typedef enum logic [2:0] {
    MD_ZERO  = 3'd0,
    MD_ONE   = 3'd1,
    MD_IMM8  = 3'd2,
    MD_IMM16 = 3'd3,
    MD_DPREL = 3'd4,
    MD_BREL  = 3'd5,
    MD_SPREL = 3'd6,
    MD_RSVD  = 3'd7
  } opd_mode_e;

  // Argument bytes consumed by each mode
  function automatic logic [1:0] arg_count(input opd_mode_e m);
    case (m)
      MD_IMM8, MD_BREL, MD_SPREL: arg_count = 2'd1;
      MD_IMM16, MD_DPREL:         arg_count = 2'd2;
      default:                    arg_count = 2'd0;
    endcase
  endfunction

  function automatic logic mode_is_mem(input opd_mode_e m);
    mode_is_mem = (m == MD_DPREL) || (m == MD_BREL) || (m == MD_SPREL);
  endfunction

endpackage

// File: rtl/opd_arg_pack.sv
module opd_arg_pack #(
  parameter int BW   = 8,
  parameter int NARG = 3
) (
  input  logic [NARG*BW-1:0] args,
  output logic [BW-1:0]      off_short,
  output logic [2*BW-1:0]    off_long
);
  logic [BW-1:0] byte_at [NARG];

  for (genvar gi = 0; gi < NARG; gi++) begin : g_split
    assign byte_at[gi] = args[gi*BW +: BW];
  end

  // Low byte first
  assign off_short = byte_at[0];
  assign off_long  = {byte_at[1], byte_at[0]};
endmodule

// File: rtl/opd_imm_sel.sv
module opd_imm_sel
  import opd_pkg::*;
#(
  parameter int BW = 8,
  localparam int AW = 2 * BW
) (
  input  opd_mode_e       mode,
  input  logic            wide,
  input  logic [BW-1:0]   off_short,
  input  logic [AW-1:0]   off_long,
  output logic [AW-1:0]   imm
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    case (mode)
      MD_ONE:   imm = ONE;
      MD_IMM8:  imm = {{BW{1'b0}}, off_short};
      MD_IMM16: imm = wide ? off_long : {{BW{1'b0}}, off_long[BW-1:0]};
      default:  imm = '0;
    endcase
  end
endmodule

// File: rtl/opd_ea_add.sv
module opd_ea_add
  import opd_pkg::*;
#(
  parameter int BW = 8,
  localparam int AW = 2 * BW
) (
  input  opd_mode_e     mode,
  input  logic [AW-1:0] dp_val,
  input  logic [AW-1:0] b_val,
  input  logic [AW-1:0] sp_val,
  input  logic [BW-1:0] off_short,
  input  logic [AW-1:0] off_long,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] base;
  logic [AW-1:0] offset;

  always_comb begin
    case (mode)
      MD_BREL:  begin base = b_val;  offset = {{BW{1'b0}}, off_short}; end
      MD_SPREL: begin base = sp_val; offset = {{BW{1'b0}}, off_short}; end
      default:  begin base = dp_val; offset = off_long;                end
    endcase
  end

  // Single shared adder; carry out is dropped so the sum wraps
  assign ea = base + offset;
endmodule

// File: rtl/opd_len_calc.sv
module opd_len_calc
  import opd_pkg::*;
#(
  parameter int NARG = 3,
  localparam int LW = $clog2(NARG + 2)
) (
  input  opd_mode_e      mode,
  input  logic           has_jump,
  output logic [LW-1:0]  len
);
  assign len = LW'(1) + LW'(arg_count(mode)) + LW'(has_jump);
endmodule

// File: rtl/opd_ea_gen.sv
module opd_ea_gen
  import opd_pkg::*;
#(
  parameter int BW   = 8,
  parameter int NARG = 3,
  localparam int AW  = 2 * BW,
  localparam int LW  = $clog2(NARG + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        mode,
  input  logic              wide,
  input  logic              has_jump,
  input  logic [NARG*BW-1:0] arg_bytes,
  input  logic [AW-1:0]     dp_val,
  input  logic [AW-1:0]     b_val,
  input  logic [AW-1:0]     sp_val,
  output logic              out_valid,
  output logic              out_is_mem,
  output logic              out_wide,
  output logic [AW-1:0]     out_value,
  output logic [LW-1:0]     out_len
);
  opd_mode_e     md;
  logic [BW-1:0] off_short;
  logic [AW-1:0] off_long;
  logic [AW-1:0] imm;
  logic [AW-1:0] ea;
  logic [LW-1:0] len;
  logic          is_mem;

  assign md     = opd_mode_e'(mode);
  assign is_mem = mode_is_mem(md);

  opd_arg_pack #(.BW(BW), .NARG(NARG)) u_pack (
    .args(arg_bytes), .off_short(off_short), .off_long(off_long)
  );

  opd_imm_sel #(.BW(BW)) u_imm (
    .mode(md), .wide(wide), .off_short(off_short), .off_long(off_long), .imm(imm)
  );

  opd_ea_add #(.BW(BW)) u_add (
    .mode(md), .dp_val(dp_val), .b_val(b_val), .sp_val(sp_val),
    .off_short(off_short), .off_long(off_long), .ea(ea)
  );

  opd_len_calc #(.NARG(NARG)) u_len (
    .mode(md), .has_jump(has_jump), .len(len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_is_mem <= 1'b0;
      out_wide   <= 1'b0;
      out_value  <= '0;
      out_len    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_is_mem <= is_mem;
        out_wide   <= wide;
        out_value  <= is_mem ? ea : imm;
        out_len    <= len;
      end
    end
  end

  // Assertions next to the output register
  p_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_value) && $stable(out_len)));

  p_implied_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 3'd0 || mode == 3'd7)) |=> (out_value == '0 && !out_is_mem));

  p_dp_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd4) |=>
      (out_is_mem && out_value == AW'($past(dp_val) + {$past(arg_bytes[2*BW-1:BW]), $past(arg_bytes[BW-1:0])})));

  p_sp_short_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd6) |=>
      (out_is_mem && out_value == AW'($past(sp_val) + AW'($past(arg_bytes[BW-1:0])))));

  p_width_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_wide == $past(wide)));

  p_len_range_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= LW'(1) && out_len <= LW'(NARG + 1)));
endmodule

// File: tb/test_opd_ea_gen.sv
module test_opd_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  mode;
  logic        wide;
  logic        has_jump;
  logic [23:0] arg_bytes;
  logic [15:0] dp_val, b_val, sp_val;
  logic        out_valid, out_is_mem, out_wide;
  logic [15:0] out_value;
  logic [2:0]  out_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opd_ea_gen i_opd_ea_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .wide(wide),
    .has_jump(has_jump), .arg_bytes(arg_bytes), .dp_val(dp_val), .b_val(b_val),
    .sp_val(sp_val), .out_valid(out_valid), .out_is_mem(out_is_mem),
    .out_wide(out_wide), .out_value(out_value), .out_len(out_len)
  );

  task automatic check(input string req, input logic [15:0] e_val, input logic e_mem,
                       input logic e_wide, input logic [2:0] e_len, input logic e_vld);
    checks++;
    if (out_value !== e_val || out_is_mem !== e_mem || out_wide !== e_wide ||
        out_len !== e_len || out_valid !== e_vld) begin
      errors++;
      $display("FAIL %s: got val=%h mem=%b wide=%b len=%0d vld=%b, expected val=%h mem=%b wide=%b len=%0d vld=%b",
               req, out_value, out_is_mem, out_wide, out_len, out_valid,
               e_val, e_mem, e_wide, e_len, e_vld);
    end
  endtask

  // Drive at a falling edge, result is registered at the next rising edge,
  // sampled at the following falling edge
  task automatic issue(input logic [2:0] m, input logic w, input logic j,
                       input logic [23:0] a);
    in_valid = 1'b1; mode = m; wide = w; has_jump = j; arg_bytes = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; mode = 3'd0; wide = 1'b0; has_jump = 1'b0;
    arg_bytes = 24'h0; dp_val = 16'h0; b_val = 16'h0; sp_val = 16'h0;
    repeat (3) @(negedge clk);
    check("R1 reset", 16'h0000, 1'b0, 1'b0, 3'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_implied;
    issue(3'd0, 1'b1, 1'b0, 24'hA5C3E7);
    check("R3 mode0 zero", 16'h0000, 1'b0, 1'b1, 3'd1, 1'b1);
    issue(3'd1, 1'b0, 1'b0, 24'hFFFFFF);
    check("R3 mode1 one", 16'h0001, 1'b0, 1'b0, 3'd1, 1'b1);
    issue(3'd7, 1'b1, 1'b0, 24'h123456);
    check("R3 mode7 as zero", 16'h0000, 1'b0, 1'b1, 3'd1, 1'b1);
  endtask

  task automatic t_imm;
    issue(3'd2, 1'b0, 1'b0, 24'h7F9A3C);
    check("R4 imm8 R11", 16'h003C, 1'b0, 1'b0, 3'd2, 1'b1);
    issue(3'd3, 1'b1, 1'b0, 24'hEE12AB);
    check("R5 imm16 wide R11", 16'h12AB, 1'b0, 1'b1, 3'd3, 1'b1);
    issue(3'd3, 1'b0, 1'b0, 24'hEE12AB);
    check("R5 imm16 narrow R9", 16'h00AB, 1'b0, 1'b0, 3'd3, 1'b1);
  endtask

  task automatic t_dp;
    dp_val = 16'h1200; b_val = 16'h4444; sp_val = 16'h5555;
    issue(3'd4, 1'b1, 1'b0, 24'h990034);
    check("R6 dp plain", 16'h1234, 1'b1, 1'b1, 3'd3, 1'b1);
    dp_val = 16'hF000;
    issue(3'd4, 1'b0, 1'b0, 24'h112010);
    check("R6 dp wrap", 16'h1010, 1'b1, 1'b0, 3'd3, 1'b1);
  endtask

  task automatic t_short;
    dp_val = 16'h7777; b_val = 16'h0100; sp_val = 16'hFFF0;
    issue(3'd5, 1'b1, 1'b0, 24'hABCD80);
    check("R7 b rel zext", 16'h0180, 1'b1, 1'b1, 3'd2, 1'b1);
    b_val = 16'hFFC0;
    issue(3'd5, 1'b0, 1'b0, 24'h0000F0);
    check("R7 b wrap", 16'h00B0, 1'b1, 1'b0, 3'd2, 1'b1);
    issue(3'd6, 1'b1, 1'b0, 24'h55AA20);
    check("R8 sp wrap", 16'h0010, 1'b1, 1'b1, 3'd2, 1'b1);
    sp_val = 16'h2000;
    issue(3'd6, 1'b0, 1'b0, 24'h0000FF);
    check("R8 sp top byte", 16'h20FF, 1'b1, 1'b0, 3'd2, 1'b1);
  endtask

  task automatic t_jump;
    dp_val = 16'h0010;
    issue(3'd4, 1'b1, 1'b1, 24'hF70001);
    check("R10 dp with jump len4 R11", 16'h0011, 1'b1, 1'b1, 3'd4, 1'b1);
    issue(3'd2, 1'b0, 1'b1, 24'h00F905);
    check("R10 imm8 with jump len3 R11", 16'h0005, 1'b0, 1'b0, 3'd3, 1'b1);
    issue(3'd1, 1'b0, 1'b1, 24'h000000);
    check("R10 implied with jump len2", 16'h0001, 1'b0, 1'b0, 3'd2, 1'b1);
  endtask

  task automatic t_hold;
    issue(3'd3, 1'b1, 1'b0, 24'h00BEEF);
    check("R2 result one cycle later", 16'hBEEF, 1'b0, 1'b1, 3'd3, 1'b1);
    mode = 3'd1; arg_bytes = 24'h0; wide = 1'b0;
    @(negedge clk);
    check("R2 idle holds", 16'hBEEF, 1'b0, 1'b1, 3'd3, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_implied();
    t_imm();
    t_dp();
    t_short();
    t_jump();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule